// File: doc/BRIEF.md
# Sensor Clock and Integration Timer

This block generates the timing for a linear image sensor from a single reference clock (nominally 60 MHz). It divides the reference down to a square-wave sensor clock whose frequency is the reference divided by twice a 9-bit divider setting. It also issues a one-cycle pixel enable on every eighth rising edge of that clock, and runs an integration window whose length is a 32-bit count of sensor-clock periods.

The divider and integration length arrive as static configuration words from a control register bank. A divider setting of zero is not a legal rate and is disregarded. Any legal new setting is adopted only where one sensor-clock period ends and the next begins, so the output never shows a shortened pulse. A one-cycle start strobe opens the integration window. At the close of the window the block drops its active flag and gives a one-cycle done pulse. Everything runs in the reference clock domain: the sensor clock is a registered data output, and downstream logic uses the pixel enable and the sensor-clock rise timing as enables.

Top module: `sensor_timing_gen`

## Requirements
- R1: With an applied divider value D, `sclk_o` is a square wave with period 2*D reference cycles, high for D cycles and low for D cycles.
- R2: Every divider value from 1 to 511 is accepted and applied, including the extremes 1 (period 2) and 511 (period 1022).
- R3: A `div_cfg_i` value of 0 is ignored; the divider previously applied stays in effect.
- R4: `div_cfg_i` is sampled only on the reference edge at which `sclk_o` goes from 0 to 1. The new value governs the period that starts at that edge, so no period is cut short.
- R5: `pix_en_o` is high for exactly one reference cycle, on the cycle in which `sclk_o` first reads 1, once every 8 rising edges of `sclk_o`. The first pulse is on the 8th rising edge after reset.
- R6: A `start_i` pulse seen while idle raises `int_active_o` on the next cycle and loads N = `int_cfg_i`. `int_active_o` falls together with the Nth rising edge of `sclk_o` that comes after the start. A rise on the same edge as the start is not counted.
- R7: An `int_cfg_i` value of 0 acts as 1. `int_done_o` is a single-cycle pulse in the cycle `int_active_o` first reads 0 after a window.
- R8: `start_i` is ignored while `int_active_o` is 1; the running count is neither restarted nor reloaded.
- R9: While `rst` is high and on the cycle after it, `sclk_o`, `pix_en_o`, `int_active_o` and `int_done_o` read 0. The applied divider is reset to the parameter `DEF_DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg_i | input | 9 | Requested divider value (0 is ignored) |
| int_cfg_i | input | 32 | Integration length in sensor-clock periods (0 means 1) |
| start_i | input | 1 | One-cycle strobe that opens an integration window |
| sclk_o | output | 1 | Registered odd/even sensor clock |
| pix_en_o | output | 1 | One-cycle pixel enable on every 8th sensor-clock rise |
| int_active_o | output | 1 | High while the integration window is open |
| int_done_o | output | 1 | One-cycle pulse at the end of a window |

## Verification
The assertions assume that reset is held for at least two reference cycles, so that every history they consult comes from reset values. They also assume the inputs change only between active edges. They make no assumption about when the divider word changes: legal values, zero and mid-period changes are all permitted, because the block itself guards the boundary. The stimulus drives every input on the falling edge of the reference clock and holds reset for three cycles. It changes the divider both in mid-period and to zero, and it pulses start both when idle and while a window is running, so the input-side freedom the assertions allow is actually exercised.

// File: rtl/stg_pkg.sv
package stg_pkg;
  parameter int unsigned STG_DIV_W   = 9;
  parameter int unsigned STG_INT_W   = 32;
  parameter int unsigned STG_PIX_DIV = 8;
  parameter int unsigned STG_DEF_DIV = 500;
endpackage

// File: rtl/stg_clk_div.sv
module stg_clk_div #(
  parameter int unsigned DIV_W   = 9,
  parameter int unsigned DEF_DIV = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             sclk,
  output logic             rise_now
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_div;
  logic             half_end;

  // end of a half period of the sensor clock
  assign half_end = (cnt == act_div - DIV_W'(1));
  assign rise_now = half_end & ~sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sclk    <= 1'b0;
      act_div <= DIV_W'(DEF_DIV);
    end else if (half_end) begin
      cnt  <= '0;
      sclk <= ~sclk;
      // period boundary: adopt a legal request only here
      if (!sclk && (div_cfg != '0))
        act_div <= div_cfg;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R3: the applied divider is never zero
  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    act_div != '0);
  // R4: the applied divider only moves at a rising boundary
  p_div_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rise_now) |-> $stable(act_div));
  // R1: the half-period counter stays below the divider
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < act_div);
endmodule

// File: rtl/stg_pix_strobe.sv
module stg_pix_strobe #(
  parameter int unsigned PIX_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_now,
  output logic pix_en
);
  localparam int unsigned PIX_W = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam logic [PIX_W-1:0] LAST = PIX_W'(PIX_DIV - 1);

  logic [PIX_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt   <= '0;
      pix_en <= 1'b0;
    end else begin
      pix_en <= rise_now && (rcnt == LAST);
      if (rise_now)
        rcnt <= (rcnt == LAST) ? '0 : rcnt + PIX_W'(1);
    end
  end

  // R5: the strobe never lasts two cycles
  p_pix_single_r5: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> !pix_en);
endmodule

// File: rtl/stg_int_timer.sv
module stg_int_timer #(
  parameter int unsigned INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [INT_W-1:0] len_cfg,
  input  logic             rise_now,
  output logic             active,
  output logic             done
);
  logic [INT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          remain <= (len_cfg == '0) ? INT_W'(1) : len_cfg;
        end
      end else if (rise_now) begin
        if (remain == INT_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          remain <= remain - INT_W'(1);
        end
      end
    end
  end

  // R7: a running window always has periods left
  p_remain_live_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> remain != '0);
  // R7: done is one cycle and follows an open window
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active)) ##1 !done);
  // R8: a start during a window does not reload the count
  p_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && active && !$past(rise_now)) |-> $stable(remain));
endmodule

// File: rtl/sensor_timing_gen.sv
module sensor_timing_gen
  import stg_pkg::*;
#(
  parameter int unsigned DIV_W   = STG_DIV_W,
  parameter int unsigned INT_W   = STG_INT_W,
  parameter int unsigned PIX_DIV = STG_PIX_DIV,
  parameter int unsigned DEF_DIV = STG_DEF_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [INT_W-1:0] int_cfg_i,
  input  logic             start_i,
  output logic             sclk_o,
  output logic             pix_en_o,
  output logic             int_active_o,
  output logic             int_done_o
);
  logic rise_now;

  stg_clk_div #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .div_cfg  (div_cfg_i),
    .sclk     (sclk_o),
    .rise_now (rise_now)
  );

  stg_pix_strobe #(.PIX_DIV(PIX_DIV)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .rise_now (rise_now),
    .pix_en   (pix_en_o)
  );

  stg_int_timer #(.INT_W(INT_W)) u_int (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .len_cfg  (int_cfg_i),
    .rise_now (rise_now),
    .active   (int_active_o),
    .done     (int_done_o)
  );

  // R5: the pixel enable coincides with a fresh rise of the sensor clock
  p_pix_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    pix_en_o |-> (sclk_o && !$past(sclk_o)));
  // R6: an open window closes only as the sensor clock rises
  p_close_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_active_o) |-> $rose(sclk_o));
endmodule

// File: tb/sensor_timing_gen_tb_top.sv
module sensor_timing_gen_tb_top;
  localparam int DEFD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  div_cfg = 9'd0;
  logic [31:0] int_cfg = 32'd0;
  logic        start = 1'b0;
  logic        sclk_o, pix_en_o, int_active_o, int_done_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sensor_timing_gen #(.DEF_DIV(DEFD)) dut_i (
    .clk(clk), .rst(rst), .div_cfg_i(div_cfg), .int_cfg_i(int_cfg),
    .start_i(start), .sclk_o(sclk_o), .pix_en_o(pix_en_o),
    .int_active_o(int_active_o), .int_done_o(int_done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int     m_cnt = 0, m_div = DEFD, m_pcnt = 0;
  bit     m_sclk = 0, m_pix = 0, m_act = 0, m_done = 0;
  longint m_rem = 0;

  always @(posedge clk) begin
    bit tick, rise;
    tick = (m_cnt == m_div - 1);
    rise = tick && !m_sclk;
    if (rst) begin
      m_cnt = 0; m_div = DEFD; m_pcnt = 0; m_sclk = 0;
      m_pix = 0; m_act = 0; m_done = 0; m_rem = 0;
    end else begin
      m_pix = rise && (m_pcnt == 7);
      if (rise) m_pcnt = (m_pcnt + 1) % 8;
      m_done = 0;
      if (!m_act) begin
        if (start) begin
          m_act = 1;
          m_rem = (int_cfg == 0) ? 1 : longint'(int_cfg);
        end
      end else if (rise) begin
        if (m_rem == 1) begin m_act = 0; m_done = 1; end
        else m_rem--;
      end
      if (tick) begin
        if (!m_sclk && div_cfg != 0) m_div = int'(div_cfg);
        m_sclk = !m_sclk;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      cyc++;
      if (!rst) begin
        chk("R1 sclk_o", sclk_o, m_sclk);
        chk("R5 pix_en_o", pix_en_o, m_pix);
        chk("R6 int_active_o", int_active_o, m_act);
        chk("R7 int_done_o", int_done_o, m_done);
      end
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic wait_rise();
    bit last;
    last = sclk_o;
    forever begin
      @(negedge clk);
      if (sclk_o && !last) break;
      last = sclk_o;
    end
  endtask

  task automatic measure(output int per, output int hi);
    bit last;
    wait_rise();
    per = 0; hi = 0; last = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (sclk_o && !last) break;
      if (sclk_o) hi++;
      last = sclk_o;
    end
    hi++; // the rising cycle itself
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!int_done_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int per, hi, n, pixn;
    repeat (3) @(negedge clk);
    // R9: outputs at rest during reset
    chk("R9 sclk in reset", sclk_o, 0);
    chk("R9 active in reset", int_active_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 sclk after reset", sclk_o, 0);
    chk("R9 pix after reset", pix_en_o, 0);
    chk("R9 done after reset", int_done_o, 0);
    // R9: default divider applies while the request is zero
    measure(per, hi);
    chk("R9 default period", per, 2 * DEFD);
    // R1 / R4: change mid-period, the new period follows the next rise
    repeat (3) @(negedge clk);
    div_cfg = 9'd3;
    measure(per, hi);
    chk("R4 period after change", per, 6);
    chk("R1 high time", hi, 3);
    // R2: both extremes
    div_cfg = 9'd1;
    measure(per, hi);
    chk("R2 period at 1", per, 2);
    // R3: zero ignored
    div_cfg = 9'd0;
    measure(per, hi);
    chk("R3 zero ignored", per, 2);
    div_cfg = 9'd511;
    measure(per, hi);
    chk("R2 period at 511", per, 1022);
    chk("R1 high time at 511", hi, 511);
    // R5: count pixel enables over 16 sensor periods at divider 2
    div_cfg = 9'd2;
    wait_rise();
    wait_rise();
    pixn = 0;
    for (int i = 0; i < 16 * 4; i++) begin
      @(negedge clk);
      if (pix_en_o) pixn++;
    end
    chk("R5 pixel enables per 16 periods", pixn, 2);
    // R6: integration of 5 periods at divider 2
    int_cfg = 32'd5;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R6 active after start", int_active_o, 1);
    wait_done(n);
    chk("R6 done seen", int_done_o, 1);
    chk("R6 window length", n, 5 * 4 - 1);
    @(negedge clk);
    chk("R7 done single", int_done_o, 0);
    // R7: zero treated as one period
    int_cfg = 32'd0;
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(n);
    chk("R7 zero length ends", int_done_o, 1);
    chk("R7 zero length window", (n <= 4) ? 1 : 0, 1);
    // R8: a second start mid-window is ignored
    int_cfg = 32'd6;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    int_cfg = 32'd40;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(n);
    chk("R8 restart ignored", (n < 20) ? 1 : 0, 1);
    repeat (20) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule